// File: doc/BRIEF.md
# Serial-Loaded Segmented Current DAC Front End

This block is the digital front end of a 16-bit current-output converter. A host shifts 24-bit words into it over three wires: a serial clock, a serial data line and a load strobe. The block samples these pins in its own system clock domain. Each rising serial-clock edge shifts one bit into a 24-bit register, most significant bit first. Shifting never waits on the strobe. A rising edge of the strobe copies whatever the register holds at that moment into the active word. That copy is always the last 24 bits shifted in, however long or short the burst was.

The active word drives the converter. Its 16-bit data field is split in two. The top four bits become a thermometer code over 15 equal-weight segment switches. The remaining twelve bits pass straight to the binary ladder switches. A 2-bit range code in the 8-bit control byte picks one of three output spans. The whole active word is also brought out for readback. All outputs are registered and change together, in the cycle after the strobe edge is detected.

Top module: `dsf_top`

## Requirements
- R1: While `rst_n` is low, all outputs are cleared: segment switches off, ladder switches off, readback zero and `range_sel` = 2'b10. The shift register is also cleared, so a burst shorter than 24 bits after reset latches zeros in its upper positions.
- R2: Each rising `sclk_in` edge samples `sdin_in` into bit 0 and moves the earlier bits up by one. After a 24-bit burst and a `latch_in` rising edge, `word_rb` equals the word as sent, with the first bit sent landing in bit 23.
- R3: A `latch_in` rising edge captures the last 24 bits shifted, with no other condition. A burst longer than 24 bits loses its oldest bits. A shorter burst leaves older bits in the upper positions.
- R4: `ladder_sw[i]` equals bit i of the latched word for i = 0..11.
- R5: `seg_sw[k]` (segment switch k+1) is on exactly when the latched bits [15:12], read as an unsigned N, satisfy N > k. N = 0 turns on no segments and N = 15 turns on all of them.
- R6: Range field bits [17:16] select `range_sel`: 2'b00 gives 0–20 mA, 2'b01 gives 0–24 mA and 2'b10 gives 4–20 mA. `range_sel` never shows 2'b11.
- R7: A latched word whose range field is 2'b11 leaves `range_sel` at its previous value. The switch outputs and readback still update.
- R8: Shifting bits with no `latch_in` rising edge changes none of the outputs.
- R9: Capture happens only on the rising edge of `latch_in`. Bits shifted while `latch_in` stays high, and its falling edge, leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdin_in | input | 1 | Serial data, MSB first |
| latch_in | input | 1 | Load strobe; rising edge captures the word |
| seg_sw | output | 15 | Thermometer segment switches, bit 0 is switch 1 |
| ladder_sw | output | 12 | Binary ladder switches, bit 0 is least significant |
| range_sel | output | 2 | Selected output range code |
| word_rb | output | 24 | Readback of the latched 24-bit word |

## Verification
The assertions rely on the serial pins changing slowly compared with `clk`. Each level must last for several system clocks, so the synchronisers deliver clean single-cycle edges. They also rely on `sdin_in` settling before `sclk_in` rises, and on a strobe edge never coinciding with a shift edge. The stimulus holds every serial phase for two or three system clocks and changes data only while the serial clock is low. It raises the strobe only after the last shift edge has had time to pass through the synchroniser.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int WORD_BITS = 24;
  localparam int DATA_BITS = 16;
  localparam int SEG_SEL_BITS = 4;
  localparam int RANGE_POS = 16;

  typedef enum logic [1:0] {
    RNG_0_20  = 2'b00,
    RNG_0_24  = 2'b01,
    RNG_4_20  = 2'b10,
    RNG_RSVD  = 2'b11
  } range_e;
endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
  parameter int W = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/dsf_shift_capture.sv
module dsf_shift_capture #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdin_s,
  input  logic              latch_s,
  output logic [WORD_W-1:0] shreg_o,
  output logic              cap_o
);
  logic sclk_d, latch_d;
  logic sclk_rise;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      latch_d <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      latch_d <= latch_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cap_o     = latch_s & ~latch_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdin_s};
  end

  assign shreg_o = shreg;
endmodule

// File: rtl/dsf_thermo_dec.sv
module dsf_thermo_dec #(
  parameter int IN_W = 4,
  localparam int OUT_W = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  level,
  output logic [OUT_W-1:0] therm
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_seg
    assign therm[k] = (int'(level) > k);
  end
endmodule

// File: rtl/dsf_top.sv
module dsf_top #(
  parameter int WORD_W      = dsf_pkg::WORD_BITS,
  parameter int DATA_W      = dsf_pkg::DATA_BITS,
  parameter int SEG_BITS    = dsf_pkg::SEG_SEL_BITS,
  parameter int RANGE_LSB   = dsf_pkg::RANGE_POS,
  parameter int SYNC_STAGES = 2,
  localparam int LADDER_W   = DATA_W - SEG_BITS,
  localparam int SEGS       = (1 << SEG_BITS) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_in,
  input  logic                sdin_in,
  input  logic                latch_in,
  output logic [SEGS-1:0]     seg_sw,
  output logic [LADDER_W-1:0] ladder_sw,
  output logic [1:0]          range_sel,
  output logic [WORD_W-1:0]   word_rb
);
  import dsf_pkg::*;

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] shreg;
  logic              cap_pulse;
  logic [SEGS-1:0]   seg_next;
  range_e            range_field;

  dsf_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({latch_in, sdin_in, sclk_in}),
    .q_out (pins_s)
  );

  dsf_shift_capture #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_s[0]),
    .sdin_s  (pins_s[1]),
    .latch_s (pins_s[2]),
    .shreg_o (shreg),
    .cap_o   (cap_pulse)
  );

  dsf_thermo_dec #(.IN_W(SEG_BITS)) u_dec (
    .level (shreg[DATA_W-1:LADDER_W]),
    .therm (seg_next)
  );

  assign range_field = range_e'(shreg[RANGE_LSB+1:RANGE_LSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_sw    <= '0;
      ladder_sw <= '0;
      word_rb   <= '0;
      range_sel <= RNG_4_20;
    end else if (cap_pulse) begin
      seg_sw    <= seg_next;
      ladder_sw <= shreg[LADDER_W-1:0];
      word_rb   <= shreg;
      if (range_field != RNG_RSVD) range_sel <= range_field;
    end
  end
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
  parameter int WORD_W   = 24,
  parameter int DATA_W   = 16,
  parameter int LADDER_W = 12,
  parameter int SEGS     = 15,
  parameter int RANGE_LSB = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cap_pulse,
  input logic [SEGS-1:0]     seg_sw,
  input logic [LADDER_W-1:0] ladder_sw,
  input logic [1:0]          range_sel,
  input logic [WORD_W-1:0]   word_rb
);
  // R5: segment vector keeps thermometer shape
  assert_seg_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_sw + 1'b1) & seg_sw) == '0);

  // R5: segment count equals latched top data nibble
  assert_seg_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_sw) == int'(word_rb[DATA_W-1:LADDER_W]));

  // R4: ladder bits follow the latched word
  assert_ladder_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ladder_sw == word_rb[LADDER_W-1:0]);

  // R6: reserved code never appears on the range output
  assert_range_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    range_sel != 2'b11);

  // R7: a range change always reflects the latched range field
  assert_range_from_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(range_sel) |-> range_sel == word_rb[RANGE_LSB+1:RANGE_LSB]);

  // R8: outputs move only in the cycle after a capture pulse
  assert_no_change_without_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_pulse) |-> ($stable(word_rb) && $stable(range_sel) && $stable(seg_sw)));
endmodule

bind dsf_top dsf_checker #(
  .WORD_W(WORD_W), .DATA_W(DATA_W), .LADDER_W(LADDER_W), .SEGS(SEGS), .RANGE_LSB(RANGE_LSB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_pulse (cap_pulse),
  .seg_sw    (seg_sw),
  .ladder_sw (ladder_sw),
  .range_sel (range_sel),
  .word_rb   (word_rb)
);

// File: tb/dsf_top_test.sv
module dsf_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b0, sdin_in = 1'b0, latch_in = 1'b0;
  logic [14:0] seg_sw;
  logic [11:0] ladder_sw;
  logic [1:0]  range_sel;
  logic [23:0] word_rb;

  int checks = 0;
  int errors = 0;
  logic [23:0] m_sh = '0;
  logic [23:0] m_word = '0;
  logic [1:0]  m_rng = 2'b10;

  always #4 clk = ~clk;

  dsf_top uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdin_in(sdin_in),
    .latch_in(latch_in), .seg_sw(seg_sw), .ladder_sw(ladder_sw),
    .range_sel(range_sel), .word_rb(word_rb)
  );

  // {burst length, bits sent MSB first from bit len-1}
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {6'd24, 32'h0000_0000},
    {6'd24, 32'h0001_FFFF},
    {6'd24, 32'h0002_8A5C},
    {6'd24, 32'h0003_1234},
    {6'd28, 32'hABC1_7F01},
    {6'd8,  32'h0000_003E},
    {6'd20, 32'h0004_0A55},
    {6'd24, 32'h00FE_F00F}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(int n, logic [31:0] pat);
    for (int i = n - 1; i >= 0; i--) begin
      sdin_in = pat[i];
      tick(2);
      sclk_in = 1'b1;
      tick(3);
      sclk_in = 1'b0;
      tick(2);
      m_sh = {m_sh[22:0], pat[i]};
    end
    tick(4);
  endtask

  task automatic model_capture();
    m_word = m_sh;
    if (m_sh[17:16] != 2'b11) m_rng = m_sh[17:16];
  endtask

  task automatic do_latch();
    latch_in = 1'b1;
    tick(4);
    latch_in = 1'b0;
    tick(6);
    model_capture();
  endtask

  function automatic logic [14:0] therm(logic [3:0] n);
    logic [14:0] t;
    for (int k = 0; k < 15; k++) t[k] = (int'(n) > k);
    return t;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(string word_req, string rng_req);
    chk(word_req, "word_rb", 32'(word_rb), 32'(m_word));
    chk("R4", "ladder_sw", 32'(ladder_sw), 32'(m_word[11:0]));
    chk("R5", "seg_sw", 32'(seg_sw), 32'(therm(m_word[15:12])));
    chk(rng_req, "range_sel", 32'(range_sel), 32'(m_rng));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R1: reset state
    check_outputs("R1", "R1");
    rst_n = 1'b1;
    tick(3);

    // Table walk: R2 full words, R3 other burst lengths, R6/R7 ranges
    for (int v = 0; v < NV; v++) begin
      int n;
      logic [31:0] pat;
      n = int'(VEC[v][37:32]);
      pat = VEC[v][31:0];
      send_bits(n, pat);
      do_latch();
      check_outputs((n == 24) ? "R2" : "R3", (m_word[17:16] == 2'b11) ? "R7" : "R6");
    end

    // R8: shift a full word with no strobe edge
    send_bits(24, 32'h0001_2345);
    check_outputs("R8", "R8");
    do_latch();
    check_outputs("R2", "R6");

    // R9: strobe held high while shifting, then falling edge
    latch_in = 1'b1;
    tick(6);
    model_capture();
    check_outputs("R9", "R9");
    send_bits(24, 32'h0000_7777);
    check_outputs("R9", "R9");
    latch_in = 1'b0;
    tick(6);
    check_outputs("R9", "R9");
    do_latch();
    check_outputs("R3", "R6");

    // R7: reserved code keeps range 00, data still updates
    send_bits(24, 32'h0000_0000);
    do_latch();
    send_bits(24, 32'h0003_C0DE);
    do_latch();
    check_outputs("R7", "R7");
    chk("R7", "range_hold", 32'(range_sel), 32'h0);

    // R1: reset mid-run clears outputs and the shift register
    rst_n = 1'b0;
    tick(2);
    m_sh = '0; m_word = '0; m_rng = 2'b10;
    check_outputs("R1", "R1");
    rst_n = 1'b1;
    tick(3);
    send_bits(8, 32'h0000_00A5);
    do_latch();
    check_outputs("R1", "R1");
    chk("R1", "short_after_reset", 32'(word_rb), 32'h0000_00A5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule